// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block keeps three outgoing CAN frames in three mailboxes and decides which one goes to the bit-level protocol engine next. The host loads a mailbox that reports empty. It writes the identifier, identifier type, length code and eight data bytes, then raises that mailbox's request bit. The scheduler moves each requested mailbox from pending to scheduled. It offers the scheduled frame to the engine with a valid/ready handshake, follows the frame while it is on the wire, and receives a done pulse with a success flag.

Two policies choose among pending mailboxes. In identifier mode the frame with the strongest CAN priority wins. In arrival mode the mailbox whose request was accepted first wins. A second configuration bit turns off automatic retransmission, so a failed attempt is reported instead of repeated. Each mailbox reports a completion flag and a success flag, and the host clears both by writing a one to the completion bit.

Top module: `canmb_sched`

## Requirements
- R1: After reset every mailbox reports empty, completion and success flags read 0, and `eng_valid` is 0.
- R2: A load (`host_load` with `host_sel`) changes the frame stored in the selected mailbox only while that mailbox is empty. A load into a non-empty mailbox is ignored, and the frame later offered is the one loaded earlier.
- R3: A request bit for an empty mailbox makes it non-empty (pending) at the next clock edge. A request for a non-empty mailbox is ignored and causes no second transmission.
- R4: One edge after a mailbox becomes pending with nothing scheduled or in flight, `eng_valid` rises with that mailbox's index and frame. `eng_valid` with `eng_ready` starts transmission, and `eng_valid` then drops. `eng_done` with `eng_ok`=1 empties the mailbox and sets its completion and success flags at that edge.
- R5: With `cfg_fifo_order`=0, the pending mailbox with the smallest 32-bit key is chosen. The key is {base ID[10:0], IDE, extended bits[17:0], 2'b00}. A standard frame uses its ID[10:0] as the base with IDE=0 and zero extension. An extended 29-bit ID uses its bits [28:18] as the base. A standard frame therefore beats an extended frame with the same base.
- R6: Pending mailboxes with equal keys are served lowest index first.
- R7: With `cfg_fifo_order`=1, pending mailboxes are served in the order their requests were accepted. Requests accepted in the same cycle are ordered by index.
- R8: With `cfg_no_retry`=0, a done with `eng_ok`=0 returns the mailbox to pending. The mailbox stays non-empty, the flags are not set, and the frame is offered again.
- R9: With `cfg_no_retry`=1, a done with `eng_ok`=0 empties the mailbox and sets completion=1, success=0.
- R10: A `host_clr` bit clears that mailbox's completion and success flags at the next edge.
- R11: At most one mailbox is scheduled or in flight at a time. A scheduled frame is not displaced by a later request, even one with a stronger priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fifo_order | input | 1 | 0: identifier priority, 1: request order |
| cfg_no_retry | input | 1 | 1: failed attempt is reported, not retried |
| host_sel | input | 2 | Mailbox index for a load |
| host_load | input | 1 | Write frame fields into the selected mailbox |
| host_id | input | 29 | Identifier (standard in [10:0]) |
| host_ide | input | 1 | 1: extended identifier |
| host_dlc | input | 4 | Data length code |
| host_data | input | 64 | Eight data bytes |
| host_req | input | 3 | Per-mailbox transmit request |
| host_clr | input | 3 | Per-mailbox clear of completion/success |
| mb_empty | output | 3 | Mailbox may be loaded |
| mb_rqcp | output | 3 | Request completed |
| mb_txok | output | 3 | Last completion was a success |
| eng_valid | output | 1 | A frame is offered to the engine |
| eng_slot | output | 2 | Index of the offered mailbox |
| eng_id | output | 29 | Offered identifier |
| eng_ide | output | 1 | Offered identifier type |
| eng_dlc | output | 4 | Offered length code |
| eng_data | output | 64 | Offered data |
| eng_ready | input | 1 | Engine accepts the offered frame |
| eng_done | input | 1 | Engine finished the frame in flight |
| eng_ok | input | 1 | Result of that frame, 1 = sent |

## Verification
A request shows on `mb_empty` one edge after it is sampled. The frame is offered one edge later still, provided nothing else is scheduled. The handshake edge clears `eng_valid` at once, and a done pulse updates the empty, completion and success flags at the edge that samples it. The bench drives inputs on the falling clock edge and reads results on the next falling edge after the edge that takes effect. It waits for `eng_valid` before recording which mailbox is offered, so a scenario's order checks follow the exact sequence of grants.

// File: rtl/canmb_pkg.sv
// Shared widths, mailbox state type, frame record and priority key.
// Assumes the CAN 2.0A/2.0B identifier sizes (11 and 29 bits).
package canmb_pkg;
    localparam int ID_W   = 29;
    localparam int STD_W  = 11;
    localparam int EXT_W  = ID_W - STD_W;
    localparam int DLC_W  = 4;
    localparam int DATA_W = 64;
    localparam int KEY_W  = STD_W + 1 + EXT_W + 2;

    typedef enum logic [1:0] {
        MB_EMPTY = 2'd0,
        MB_PEND  = 2'd1,
        MB_SCHED = 2'd2,
        MB_TXING = 2'd3
    } mb_state_t;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ide;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } mb_frame_t;

    // Arbitration key: smaller value wins on the bus.
    function automatic logic [KEY_W-1:0] prio_key(input logic [ID_W-1:0] id, input logic ide);
        if (ide)
            return {id[ID_W-1:EXT_W], 1'b1, id[EXT_W-1:0], 2'b00};
        else
            return {id[STD_W-1:0], 1'b0, {EXT_W{1'b0}}, 2'b00};
    endfunction
endpackage

// File: rtl/canmb_slot.sv
// One transmit mailbox: frame storage, lifecycle state and status flags.
// Assumes grant, take and done reach it only in the matching state.
module canmb_slot
    import canmb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_en,
    input  mb_frame_t ld_frame,
    input  logic      req,
    input  logic      grant,
    input  logic      take,
    input  logic      done,
    input  logic      ok,
    input  logic      no_retry,
    input  logic      clr,
    output mb_state_t state,
    output mb_frame_t frame,
    output logic      rqcp,
    output logic      txok
);
    logic finish;
    assign finish = (state == MB_TXING) && done && (ok || no_retry);

    // Frame storage: written only while the mailbox is empty.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame <= '0;
        else if (load_en && state == MB_EMPTY)
            frame <= ld_frame;
    end

    // Lifecycle: empty -> pending -> scheduled -> transmitting -> empty or pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MB_EMPTY;
        end else begin
            case (state)
                MB_EMPTY: if (req)   state <= MB_PEND;
                MB_PEND:  if (grant) state <= MB_SCHED;
                MB_SCHED: if (take)  state <= MB_TXING;
                MB_TXING: if (done)  state <= (ok || no_retry) ? MB_EMPTY : MB_PEND;
                default:             state <= MB_EMPTY;
            endcase
        end
    end

    // Completion/success flags: completion sets them, host clear drops them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rqcp <= 1'b0;
            txok <= 1'b0;
        end else if (finish) begin
            rqcp <= 1'b1;
            txok <= ok;
        end else if (clr) begin
            rqcp <= 1'b0;
            txok <= 1'b0;
        end
    end

    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && state != MB_EMPTY) |=> frame == $past(frame)); // R2
    AST_REQ_TO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_EMPTY && req) |=> state == MB_PEND); // R3
    AST_OK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_TXING && done && ok) |=> (state == MB_EMPTY && rqcp && txok)); // R4
    AST_RETRY_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_TXING && done && !ok && !no_retry) |=> state == MB_PEND); // R8
    AST_NORETRY_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MB_TXING && done && !ok && no_retry) |=> (state == MB_EMPTY && rqcp && !txok)); // R9
    AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(state == MB_TXING && done)) |=> (!rqcp && !txok)); // R10
endmodule

// File: rtl/canmb_order.sv
// Arrival rank per mailbox: 0 is the oldest occupied mailbox.
// Assumes at most one mailbox leaves per cycle; arrivals are onto empty mailboxes.
module canmb_order #(
    parameter int N  = 3,
    parameter int RW = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          occ,
    input  logic [N-1:0]          arrive,
    input  logic [N-1:0]          leave,
    output logic [N-1:0][RW-1:0]  rank
);
    logic [N-1:0][RW-1:0] rank_nx;
    logic [RW-1:0]        leave_rank;
    logic                 any_leave;

    // Rank of the mailbox leaving this cycle, if any.
    always_comb begin
        leave_rank = '0;
        any_leave  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (leave[i]) begin
                leave_rank = rank[i];
                any_leave  = 1'b1;
            end
        end
    end

    // Next ranks: newcomers go behind survivors, survivors close the gap.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            int cnt;
            cnt = 0;
            if (arrive[i]) begin
                for (int j = 0; j < N; j++) begin
                    if (j != i && occ[j] && !leave[j]) cnt++;
                    if (j < i && arrive[j]) cnt++;
                end
                rank_nx[i] = RW'(cnt);
            end else if (any_leave && occ[i] && rank[i] > leave_rank) begin
                rank_nx[i] = rank[i] - 1'b1;
            end else begin
                rank_nx[i] = rank[i];
            end
        end
    end

    // Rank registers.
    always_ff @(posedge clk) begin
        if (!rst_n) rank <= '0;
        else        rank <= rank_nx;
    end
endmodule

// File: rtl/canmb_pick.sv
// Chooses one pending mailbox by key (smallest) or by arrival rank (oldest).
// Strict comparison keeps the lowest index on ties. Purely combinational.
module canmb_pick
    import canmb_pkg::*;
#(
    parameter int N  = 3,
    parameter int RW = 2
) (
    input  logic                  enable,
    input  logic                  fifo_mode,
    input  logic [N-1:0]          pend,
    input  logic [N-1:0][KEY_W-1:0] keys,
    input  logic [N-1:0][RW-1:0]  rank,
    output logic [N-1:0]          grant
);
    // Linear scan for the best pending candidate.
    always_comb begin
        int   best;
        logic found;
        best  = 0;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i]) begin
                if (!found || (fifo_mode ? (rank[i] < rank[best]) : (keys[i] < keys[best]))) begin
                    best  = i;
                    found = 1'b1;
                end
            end
        end
        if (enable && found) grant[best] = 1'b1;
    end
endmodule

// File: rtl/canmb_sched.sv
// Top: three transmit mailboxes, selection policy and engine handshake.
// Assumes the engine raises eng_done only for a frame it has accepted.
module canmb_sched
    import canmb_pkg::*;
#(
    parameter int N_MB  = 3,
    parameter int SEL_W = (N_MB > 1) ? $clog2(N_MB) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_fifo_order,
    input  logic                 cfg_no_retry,
    input  logic [SEL_W-1:0]     host_sel,
    input  logic                 host_load,
    input  logic [ID_W-1:0]      host_id,
    input  logic                 host_ide,
    input  logic [DLC_W-1:0]     host_dlc,
    input  logic [DATA_W-1:0]    host_data,
    input  logic [N_MB-1:0]      host_req,
    input  logic [N_MB-1:0]      host_clr,
    output logic [N_MB-1:0]      mb_empty,
    output logic [N_MB-1:0]      mb_rqcp,
    output logic [N_MB-1:0]      mb_txok,
    output logic                 eng_valid,
    output logic [SEL_W-1:0]     eng_slot,
    output logic [ID_W-1:0]      eng_id,
    output logic                 eng_ide,
    output logic [DLC_W-1:0]     eng_dlc,
    output logic [DATA_W-1:0]    eng_data,
    input  logic                 eng_ready,
    input  logic                 eng_done,
    input  logic                 eng_ok
);
    mb_frame_t                   ld_frame;
    mb_state_t [N_MB-1:0]        st;
    mb_frame_t [N_MB-1:0]        frm;
    logic [N_MB-1:0][KEY_W-1:0]  keys;
    logic [N_MB-1:0][SEL_W-1:0]  rank;
    logic [N_MB-1:0]             pend, sched, txing, grant, arrive, leave, done_v;
    logic                        take;
    mb_frame_t                   out_frame;

    assign ld_frame = '{id: host_id, ide: host_ide, dlc: host_dlc, data: host_data};
    assign take     = eng_valid && eng_ready;

    for (genvar g = 0; g < N_MB; g++) begin : g_mb
        assign pend[g]     = (st[g] == MB_PEND);
        assign sched[g]    = (st[g] == MB_SCHED);
        assign txing[g]    = (st[g] == MB_TXING);
        assign mb_empty[g] = (st[g] == MB_EMPTY);
        assign done_v[g]   = eng_done && txing[g];
        assign arrive[g]   = host_req[g] && mb_empty[g];
        assign leave[g]    = done_v[g] && (eng_ok || cfg_no_retry);
        assign keys[g]     = prio_key(frm[g].id, frm[g].ide);

        canmb_slot i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (host_load && host_sel == SEL_W'(g)),
            .ld_frame (ld_frame),
            .req      (host_req[g]),
            .grant    (grant[g]),
            .take     (take && sched[g]),
            .done     (done_v[g]),
            .ok       (eng_ok),
            .no_retry (cfg_no_retry),
            .clr      (host_clr[g]),
            .state    (st[g]),
            .frame    (frm[g]),
            .rqcp     (mb_rqcp[g]),
            .txok     (mb_txok[g])
        );
    end

    canmb_order #(.N(N_MB), .RW(SEL_W)) i_order (
        .clk    (clk),
        .rst_n  (rst_n),
        .occ    (~mb_empty),
        .arrive (arrive),
        .leave  (leave),
        .rank   (rank)
    );

    canmb_pick #(.N(N_MB), .RW(SEL_W)) i_pick (
        .enable    (~|(sched | txing)),
        .fifo_mode (cfg_fifo_order),
        .pend      (pend),
        .keys      (keys),
        .rank      (rank),
        .grant     (grant)
    );

    // Offer mux: present the scheduled mailbox to the engine.
    always_comb begin
        eng_slot  = '0;
        out_frame = '0;
        for (int i = 0; i < N_MB; i++) begin
            if (sched[i]) begin
                eng_slot  = SEL_W'(i);
                out_frame = frm[i];
            end
        end
    end

    assign eng_valid = |sched;
    assign eng_id    = out_frame.id;
    assign eng_ide   = out_frame.ide;
    assign eng_dlc   = out_frame.dlc;
    assign eng_data  = out_frame.data;

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sched | txing) <= 1); // R11
    AST_NO_GRANT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sched | txing)) |-> grant == '0); // R11
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R6
    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pend) == '0); // R5
    AST_OFFER_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
        eng_valid |-> !mb_empty[eng_slot]); // R4
endmodule

// File: tb/test_canmb_sched.sv
`timescale 1ns/1ps
module test_canmb_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fifo_order = 1'b0, cfg_no_retry = 1'b0;
    logic [1:0]  host_sel = '0;
    logic        host_load = 1'b0;
    logic [28:0] host_id = '0;
    logic        host_ide = 1'b0;
    logic [3:0]  host_dlc = '0;
    logic [63:0] host_data = '0;
    logic [2:0]  host_req = '0, host_clr = '0;
    logic [2:0]  mb_empty, mb_rqcp, mb_txok;
    logic        eng_valid;
    logic [1:0]  eng_slot;
    logic [28:0] eng_id;
    logic        eng_ide;
    logic [3:0]  eng_dlc;
    logic [63:0] eng_data;
    logic        eng_ready = 1'b0, eng_done = 1'b0, eng_ok = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    canmb_sched i_canmb_sched (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_order(cfg_fifo_order), .cfg_no_retry(cfg_no_retry),
        .host_sel(host_sel), .host_load(host_load), .host_id(host_id), .host_ide(host_ide),
        .host_dlc(host_dlc), .host_data(host_data), .host_req(host_req), .host_clr(host_clr),
        .mb_empty(mb_empty), .mb_rqcp(mb_rqcp), .mb_txok(mb_txok),
        .eng_valid(eng_valid), .eng_slot(eng_slot), .eng_id(eng_id), .eng_ide(eng_ide),
        .eng_dlc(eng_dlc), .eng_data(eng_data),
        .eng_ready(eng_ready), .eng_done(eng_done), .eng_ok(eng_ok)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic load(input logic [1:0] sel, input logic [28:0] id, input logic ide,
                        input logic [63:0] data);
        host_sel = sel; host_id = id; host_ide = ide; host_dlc = 4'd8; host_data = data;
        host_load = 1'b1;
        tick();
        host_load = 1'b0;
    endtask

    task automatic request(input logic [2:0] mask);
        host_req = mask;
        tick();
        host_req = '0;
    endtask

    task automatic clear(input logic [2:0] mask);
        host_clr = mask;
        tick();
        host_clr = '0;
    endtask

    // Engine stub: wait for an offer, accept it, then finish with the given result.
    task automatic serve(input logic ok, output logic [1:0] slot, output logic [28:0] id,
                         output logic [63:0] data);
        int n;
        n = 0;
        while (!eng_valid && n < 40) begin
            tick();
            n++;
        end
        chk("R4 offer appears", eng_valid, 1'b1);
        slot = eng_slot; id = eng_id; data = eng_data;
        eng_ready = 1'b1;
        tick();
        eng_ready = 1'b0;
        chk("R4 valid drops after accept", eng_valid, 1'b0);
        eng_done = 1'b1; eng_ok = ok;
        tick();
        eng_done = 1'b0; eng_ok = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 all empty", mb_empty, 3'b111);
        chk("R1 rqcp zero", mb_rqcp, 3'b000);
        chk("R1 txok zero", mb_txok, 3'b000);
        chk("R1 no offer", eng_valid, 1'b0);
    endtask

    task automatic t_basic();
        logic [1:0] s; logic [28:0] id; logic [63:0] d;
        load(2'd1, 29'h123, 1'b0, 64'h1122334455667788);
        chk("R3 load alone keeps empty", mb_empty[1], 1'b1);
        request(3'b010);
        chk("R3 request makes pending", mb_empty[1], 1'b0);
        chk("R4 no offer same edge", eng_valid, 1'b0);
        tick();
        chk("R4 offer one edge later", eng_valid, 1'b1);
        chk("R4 offered slot", eng_slot, 2'd1);
        chk("R4 offered id", eng_id, 29'h123);
        serve(1'b1, s, id, d);
        chk("R4 data", d, 64'h1122334455667788);
        chk("R4 empty after ok", mb_empty[1], 1'b1);
        chk("R4 rqcp set", mb_rqcp[1], 1'b1);
        chk("R4 txok set", mb_txok[1], 1'b1);
        clear(3'b010);
        chk("R10 rqcp cleared", mb_rqcp[1], 1'b0);
        chk("R10 txok cleared", mb_txok[1], 1'b0);
    endtask

    task automatic t_ignore();
        logic [1:0] s; logic [28:0] id; logic [63:0] d;
        load(2'd0, 29'h044, 1'b0, 64'hAAAA);
        request(3'b001);
        load(2'd0, 29'h055, 1'b0, 64'hBBBB);
        request(3'b001);
        serve(1'b1, s, id, d);
        chk("R2 id kept", id, 29'h044);
        chk("R2 data kept", d, 64'hAAAA);
        repeat (5) tick();
        chk("R3 no second send", eng_valid, 1'b0);
        chk("R3 mailbox empty", mb_empty[0], 1'b1);
        clear(3'b111);
    endtask

    task automatic t_idprio();
        logic [1:0] s; logic [28:0] id; logic [63:0] d;
        cfg_fifo_order = 1'b0;
        load(2'd0, 29'h300, 1'b0, 64'h0);
        load(2'd1, (29'h100 << 18) | 29'h5, 1'b1, 64'h1);
        load(2'd2, 29'h100, 1'b0, 64'h2);
        request(3'b111);
        serve(1'b1, s, id, d); chk("R5 first lowest key std", s, 2'd2);
        serve(1'b1, s, id, d); chk("R5 ext same base second", s, 2'd1);
        serve(1'b1, s, id, d); chk("R5 highest key last", s, 2'd0);
        clear(3'b111);
    endtask

    task automatic t_tie();
        logic [1:0] s; logic [28:0] id; logic [63:0] d;
        load(2'd1, 29'h055, 1'b0, 64'h0);
        load(2'd2, 29'h055, 1'b0, 64'h0);
        request(3'b110);
        serve(1'b1, s, id, d); chk("R6 tie lowest index", s, 2'd1);
        serve(1'b1, s, id, d); chk("R6 tie other next", s, 2'd2);
        clear(3'b111);
    endtask

    task automatic t_order();
        logic [1:0] s; logic [28:0] id; logic [63:0] d;
        cfg_fifo_order = 1'b1;
        load(2'd2, 29'h700, 1'b0, 64'h0);
        load(2'd1, 29'h010, 1'b0, 64'h0);
        load(2'd0, 29'h001, 1'b0, 64'h0);
        request(3'b100);
        request(3'b010);
        request(3'b001);
        serve(1'b1, s, id, d); chk("R7 first requested", s, 2'd2);
        serve(1'b1, s, id, d); chk("R7 second requested beats lower id", s, 2'd1);
        serve(1'b1, s, id, d); chk("R7 last requested", s, 2'd0);
        cfg_fifo_order = 1'b0;
        clear(3'b111);
    endtask

    task automatic t_retry();
        logic [1:0] s; logic [28:0] id; logic [63:0] d;
        cfg_no_retry = 1'b0;
        load(2'd1, 29'h222, 1'b0, 64'h0);
        request(3'b010);
        serve(1'b0, s, id, d);
        chk("R8 stays occupied", mb_empty[1], 1'b0);
        chk("R8 no completion", mb_rqcp[1], 1'b0);
        serve(1'b1, s, id, d);
        chk("R8 re-offered", s, 2'd1);
        chk("R8 success after retry", mb_txok[1], 1'b1);
        clear(3'b111);
    endtask

    task automatic t_noretry();
        logic [1:0] s; logic [28:0] id; logic [63:0] d;
        cfg_no_retry = 1'b1;
        load(2'd2, 29'h333, 1'b0, 64'h0);
        request(3'b100);
        serve(1'b0, s, id, d);
        chk("R9 emptied", mb_empty[2], 1'b1);
        chk("R9 rqcp set", mb_rqcp[2], 1'b1);
        chk("R9 txok clear", mb_txok[2], 1'b0);
        repeat (3) tick();
        chk("R9 not retried", eng_valid, 1'b0);
        cfg_no_retry = 1'b0;
        clear(3'b111);
    endtask

    task automatic t_nopreempt();
        logic [1:0] s; logic [28:0] id; logic [63:0] d;
        load(2'd0, 29'h400, 1'b0, 64'h0);
        request(3'b001);
        tick();
        load(2'd1, 29'h001, 1'b0, 64'h0);
        request(3'b010);
        repeat (3) tick();
        chk("R11 scheduled frame kept", eng_slot, 2'd0);
        serve(1'b1, s, id, d); chk("R11 first served", s, 2'd0);
        serve(1'b1, s, id, d); chk("R11 later one next", s, 2'd1);
        clear(3'b111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_basic();
        t_ignore();
        t_idprio();
        t_tie();
        t_order();
        t_retry();
        t_noretry();
        t_nopreempt();
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
        $finish;
    end
endmodule